// File: doc/BRIEF.md
# Four-User Interprocessor Mailbox Hub

This block lets up to four processors exchange 32-bit words through eight shared message queues, each four entries deep. Any processor may post a word into any queue by writing that queue's message register, and may take the oldest word out by reading the same register. Every user owns a private set of event registers. The first is a latched raw event word holding two bits per queue, one for "a message arrived" and one for "space opened up". The second is an enable mask, changed through separate write-1-to-set and write-1-to-clear addresses. The third is a masked view whose writes clear latched events. Each user's interrupt line is high while any of its enabled events is pending. Any queue can therefore wake any subset of the users.

All access goes through one simple register bus: a request carries valid, write, an 8-bit word address and 32-bit write data. The hub never applies back-pressure: `bus_ready` is always high, and every cycle with `bus_valid` high is one accepted transaction. A read's data returns on `rsp_data` with `rsp_valid` one cycle after acceptance. The response has no back-pressure, so the requester must take it in that cycle. Writes produce no response.

Address layout: in bits [7:5], 0 selects the queue region and 1 selects the user region. In the queue region, bits [4:3] pick message (0), count (1) or full flag (2), and bits [2:0] pick the queue. In the user region, bits [4:2] pick the user and bits [1:0] pick raw (0), masked/clear (1), enable-set (2) or enable-clear (3). Event bit 2m belongs to queue m's arrival event and bit 2m+1 to its space event.

Top module: `mbx_hub`

## Requirements
- R1: After reset all queues are empty, every count and full flag reads 0, every raw word and enable mask reads 0, all `irq` lines are low and `rsp_valid` is low.
- R2: A write to queue m's message address (0x00+m) while it holds fewer than 4 words appends the word and raises its count (0x08+m) by one. The count never exceeds 4. The full flag (0x10+m) reads 1 exactly when the count is 4.
- R3: Reads of queue m's message address return the words in the order they were posted, removing one word per accepted read and lowering the count by one.
- R4: A write to a queue that holds 4 words is discarded: count and contents are unchanged.
- R5: A read from an empty queue returns the last word removed from that queue (0 if none yet) and leaves the queue empty.
- R6: Writing the enable-set address (0x20+4u+2) sets the mask bits where the data has 1s. Writing the enable-clear address (0x20+4u+3) clears them. Data bits that are 0 leave the mask unchanged. Both addresses read back the mask.
- R7: For every user, raw bit 2m latches when a word is accepted into queue m, and raw bit 2m+1 latches when a word is removed from a full queue m, regardless of enables. The raw word (0x20+4u) reads it.
- R8: Writing 1s to the masked/clear address (0x20+4u+1) clears those latched raw bits of user u only. A cleared bit stays 0 until its event occurs again.
- R9: The masked address reads raw AND enable, and `irq[u]` is high exactly when that masked word is nonzero.
- R10: `bus_ready` is always 1. Each accepted read gives `rsp_valid` high in the next cycle, and each write or idle cycle gives it low in the next cycle. Reads of unmapped addresses return 0.
- R11: Queues are independent: traffic on one queue changes no other queue's contents or count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_valid | input | 1 | Request present this cycle |
| bus_ready | output | 1 | Request accepted (always 1) |
| bus_write | input | 1 | 1 for write, 0 for read |
| bus_addr | input | 8 | Word address |
| bus_wdata | input | 32 | Write data |
| rsp_valid | output | 1 | Read data valid, one cycle after the read |
| rsp_data | output | 32 | Read data |
| irq | output | 4 | Per-user interrupt, high while an enabled event is pending |

## Verification
The assertions assume that `bus_valid`, `bus_write` and `bus_addr` carry known values in every cycle after reset. They also assume at most one transaction per cycle, which the single request port guarantees. The bench changes these inputs only on the falling clock edge and returns `bus_valid` low between transactions. Its random traffic draws addresses only from the decoded queue and user registers plus one deliberately unmapped address. This keeps every property's antecedent meaningful, including writes to full queues and reads from empty ones.

// File: rtl/mbx_pkg.sv
package mbx_pkg;
  localparam int MBX_AW = 8;

  typedef enum logic [2:0] {
    RGN_QUEUE = 3'd0,
    RGN_USER  = 3'd1
  } region_e;

  typedef enum logic [1:0] {
    AR_MSG  = 2'd0,
    AR_CNT  = 2'd1,
    AR_FULL = 2'd2,
    AR_NONE = 2'd3
  } q_area_e;

  typedef enum logic [1:0] {
    UR_RAW   = 2'd0,
    UR_STAT  = 2'd1,
    UR_ENSET = 2'd2,
    UR_ENCLR = 2'd3
  } u_reg_e;
endpackage

// File: rtl/mbx_queue.sv
module mbx_queue #(
  parameter int DEPTH = 4,
  parameter int DW    = 32,
  localparam int PW   = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          push,
  input  logic          pop,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] head,
  output logic [CW-1:0] count,
  output logic          full,
  output logic          pushed,
  output logic          freed
);
  logic [DW-1:0] mem [DEPTH];
  logic [PW-1:0] wr_ptr, rd_ptr;
  logic [DW-1:0] last_q;
  logic          empty, pop_ok;

  assign full   = (count == CW'(DEPTH));
  assign empty  = (count == '0);
  assign pushed = push && !full;
  assign pop_ok = pop && !empty;
  assign freed  = pop_ok && full;
  // an empty queue repeats the word it gave out last
  assign head   = empty ? last_q : mem[rd_ptr];

  function automatic logic [PW-1:0] nxt(input logic [PW-1:0] p);
    return (p == PW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk) begin
    if (pushed) mem[wr_ptr] <= wdata;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
      last_q <= '0;
    end else begin
      if (pushed) wr_ptr <= nxt(wr_ptr);
      if (pop_ok) begin
        rd_ptr <= nxt(rd_ptr);
        last_q <= mem[rd_ptr];
      end
      case ({pushed, pop_ok})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
    end
  end
endmodule

// File: rtl/mbx_user.sv
module mbx_user #(
  parameter int NQ  = 8,
  localparam int SW = 2 * NQ
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [NQ-1:0] ev_new,
  input  logic [NQ-1:0] ev_space,
  input  logic          en_set,
  input  logic          en_clr,
  input  logic          st_clr,
  input  logic [SW-1:0] wmask,
  output logic [SW-1:0] raw,
  output logic [SW-1:0] en,
  output logic          irq
);
  logic [SW-1:0] ev;

  for (genvar q = 0; q < NQ; q++) begin : g_ev
    assign ev[2*q]   = ev_new[q];
    assign ev[2*q+1] = ev_space[q];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      raw <= '0;
      en  <= '0;
    end else begin
      // a fresh event wins over a clear in the same cycle
      raw <= (raw & ~(st_clr ? wmask : '0)) | ev;
      if (en_set)      en <= en | wmask;
      else if (en_clr) en <= en & ~wmask;
    end
  end

  assign irq = |(raw & en);
endmodule

// File: rtl/mbx_hub.sv
module mbx_hub
  import mbx_pkg::*;
#(
  parameter int NQ    = 8,
  parameter int NU    = 4,
  parameter int DEPTH = 4,
  parameter int DW    = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_valid,
  output logic              bus_ready,
  input  logic              bus_write,
  input  logic [MBX_AW-1:0] bus_addr,
  input  logic [DW-1:0]     bus_wdata,
  output logic              rsp_valid,
  output logic [DW-1:0]     rsp_data,
  output logic [NU-1:0]     irq
);
  localparam int CW = $clog2(DEPTH + 1);
  localparam int SW = 2 * NQ;

  region_e rgn;
  q_area_e area;
  u_reg_e  ureg;
  logic [2:0] qidx, uidx;
  logic       q_msg;

  assign bus_ready = 1'b1;
  assign rgn  = region_e'(bus_addr[7:5]);
  assign area = q_area_e'(bus_addr[4:3]);
  assign qidx = bus_addr[2:0];
  assign uidx = bus_addr[4:2];
  assign ureg = u_reg_e'(bus_addr[1:0]);
  assign q_msg = bus_valid && (rgn == RGN_QUEUE) && (area == AR_MSG);

  logic [NQ-1:0][DW-1:0] q_head;
  logic [NQ-1:0][CW-1:0] q_cnt;
  logic [NQ-1:0]         q_full, ev_new, ev_space;

  for (genvar q = 0; q < NQ; q++) begin : g_q
    mbx_queue #(.DEPTH(DEPTH), .DW(DW)) u_queue (
      .clk    (clk),
      .rst_n  (rst_n),
      .push   (q_msg && bus_write && (qidx == 3'(q))),
      .pop    (q_msg && !bus_write && (qidx == 3'(q))),
      .wdata  (bus_wdata),
      .head   (q_head[q]),
      .count  (q_cnt[q]),
      .full   (q_full[q]),
      .pushed (ev_new[q]),
      .freed  (ev_space[q])
    );
  end

  logic [NU-1:0][SW-1:0] usr_raw, usr_en;

  for (genvar u = 0; u < NU; u++) begin : g_u
    logic hit;
    assign hit = bus_valid && bus_write && (rgn == RGN_USER) && (uidx == 3'(u));
    mbx_user #(.NQ(NQ)) u_user (
      .clk      (clk),
      .rst_n    (rst_n),
      .ev_new   (ev_new),
      .ev_space (ev_space),
      .en_set   (hit && (ureg == UR_ENSET)),
      .en_clr   (hit && (ureg == UR_ENCLR)),
      .st_clr   (hit && (ureg == UR_STAT)),
      .wmask    (bus_wdata[SW-1:0]),
      .raw      (usr_raw[u]),
      .en       (usr_en[u]),
      .irq      (irq[u])
    );
  end

  logic [DW-1:0] rd_val;

  always_comb begin
    rd_val = '0;
    if (rgn == RGN_QUEUE) begin
      for (int q = 0; q < NQ; q++) begin
        if (qidx == 3'(q)) begin
          case (area)
            AR_MSG:  rd_val = q_head[q];
            AR_CNT:  rd_val = DW'(q_cnt[q]);
            AR_FULL: rd_val = DW'(q_full[q]);
            default: rd_val = '0;
          endcase
        end
      end
    end else if (rgn == RGN_USER) begin
      for (int u = 0; u < NU; u++) begin
        if (uidx == 3'(u)) begin
          case (ureg)
            UR_RAW:  rd_val = DW'(usr_raw[u]);
            UR_STAT: rd_val = DW'(usr_raw[u] & usr_en[u]);
            default: rd_val = DW'(usr_en[u]);
          endcase
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_data  <= '0;
    end else begin
      rsp_valid <= bus_valid && !bus_write;
      if (bus_valid && !bus_write) rsp_data <= rd_val;
    end
  end
endmodule

// File: rtl/mbx_hub_chk.sv
module mbx_hub_chk #(
  parameter int NQ    = 8,
  parameter int NU    = 4,
  parameter int DEPTH = 4,
  localparam int CW   = $clog2(DEPTH + 1),
  localparam int SW   = 2 * NQ
) (
  input logic                  clk,
  input logic                  rst_n,
  input logic                  bus_valid,
  input logic                  bus_write,
  input logic [7:0]            bus_addr,
  input logic [SW-1:0]         wmask,
  input logic [NQ-1:0][CW-1:0] q_cnt,
  input logic [NQ-1:0]         q_full,
  input logic [NU-1:0][SW-1:0] usr_en,
  input logic [NU-1:0]         irq,
  input logic                  rsp_valid
);
  for (genvar q = 0; q < NQ; q++) begin : g_qa
    AST_COUNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
      q_cnt[q] <= CW'(DEPTH)); // R2
    AST_DROP_WHEN_FULL: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_valid && bus_write && bus_addr == 8'(q) && q_full[q]) |=> (q_cnt[q] == CW'(DEPTH))); // R4
    AST_EMPTY_READ_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_valid && !bus_write && bus_addr == 8'(q) && q_cnt[q] == '0) |=> (q_cnt[q] == '0)); // R5
  end

  for (genvar u = 0; u < NU; u++) begin : g_ua
    AST_IRQ_NEEDS_ENABLE: assert property (@(posedge clk) disable iff (!rst_n)
      (usr_en[u] == '0) |-> !irq[u]); // R9
    AST_ENABLE_SET: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_valid && bus_write && bus_addr == 8'(32 + 4*u + 2)) |=> ((usr_en[u] & $past(wmask)) == $past(wmask))); // R6
  end

  AST_RSP_AFTER_READ: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_valid && !bus_write) |=> rsp_valid); // R10
  AST_NO_RSP_OTHERWISE: assert property (@(posedge clk) disable iff (!rst_n)
    !(bus_valid && !bus_write) |=> !rsp_valid); // R10
endmodule

bind mbx_hub mbx_hub_chk #(.NQ(NQ), .NU(NU), .DEPTH(DEPTH)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .bus_valid (bus_valid),
  .bus_write (bus_write),
  .bus_addr  (bus_addr),
  .wmask     (bus_wdata[2*NQ-1:0]),
  .q_cnt     (q_cnt),
  .q_full    (q_full),
  .usr_en    (usr_en),
  .irq       (irq),
  .rsp_valid (rsp_valid)
);

// File: tb/mbx_hub_test.sv
module mbx_hub_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_valid = 1'b0;
  logic        bus_ready;
  logic        bus_write = 1'b0;
  logic [7:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic        rsp_valid;
  logic [31:0] rsp_data;
  logic [3:0]  irq;

  int total = 0;
  int bad = 0;
  bit done = 0;

  always #4 clk = ~clk;

  mbx_hub uut (
    .clk(clk), .rst_n(rst_n), .bus_valid(bus_valid), .bus_ready(bus_ready),
    .bus_write(bus_write), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .rsp_valid(rsp_valid), .rsp_data(rsp_data), .irq(irq)
  );

  // behavioural reference model
  logic [31:0] qm [8][$];
  logic [31:0] lastm [8];
  logic [15:0] raw_m [4];
  logic [15:0] en_m [4];
  logic        exp_rv;
  logic [31:0] exp_rd;
  string       exp_tag;

  function automatic logic [31:0] mread(input logic [7:0] a, output string tag);
    int q, u;
    tag = "R10";
    if (a[7:5] == 3'd0) begin
      q = int'(a[2:0]);
      case (a[4:3])
        2'd0: begin tag = "R3"; return (qm[q].size() > 0) ? qm[q][0] : lastm[q]; end
        2'd1: begin tag = "R2"; return 32'(qm[q].size()); end
        2'd2: begin tag = "R2"; return (qm[q].size() == 4) ? 32'd1 : 32'd0; end
        default: return 32'd0;
      endcase
    end else if (a[7:5] == 3'd1 && a[4:2] < 3'd4) begin
      u = int'(a[4:2]);
      case (a[1:0])
        2'd0: begin tag = "R7"; return 32'(raw_m[u]); end
        2'd1: begin tag = "R9"; return 32'(raw_m[u] & en_m[u]); end
        default: begin tag = "R6"; return 32'(en_m[u]); end
      endcase
    end
    return 32'd0;
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < 8; i++) begin qm[i].delete(); lastm[i] = '0; end
      for (int i = 0; i < 4; i++) begin raw_m[i] = '0; en_m[i] = '0; end
      exp_rv = 1'b0;
      exp_rd = '0;
    end else begin
      exp_rv = bus_valid && !bus_write;
      if (exp_rv) exp_rd = mread(bus_addr, exp_tag);
      if (bus_valid && bus_addr[7:5] == 3'd0 && bus_addr[4:3] == 2'd0) begin
        int q;
        q = int'(bus_addr[2:0]);
        if (bus_write) begin
          if (qm[q].size() < 4) begin
            qm[q].push_back(bus_wdata);
            for (int u = 0; u < 4; u++) raw_m[u][2*q] = 1'b1;
          end
        end else if (qm[q].size() > 0) begin
          if (qm[q].size() == 4)
            for (int u = 0; u < 4; u++) raw_m[u][2*q+1] = 1'b1;
          lastm[q] = qm[q].pop_front();
        end
      end else if (bus_valid && bus_write && bus_addr[7:5] == 3'd1 && bus_addr[4:2] < 3'd4) begin
        int u;
        u = int'(bus_addr[4:2]);
        case (bus_addr[1:0])
          2'd1: raw_m[u] = raw_m[u] & ~bus_wdata[15:0];
          2'd2: en_m[u]  = en_m[u] | bus_wdata[15:0];
          2'd3: en_m[u]  = en_m[u] & ~bus_wdata[15:0];
          default: ;
        endcase
      end
    end
  end

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  // cycle-by-cycle comparison against the model
  always @(negedge clk) begin
    if (rst_n && !done) begin
      logic [3:0] ei;
      for (int u = 0; u < 4; u++) ei[u] = |(raw_m[u] & en_m[u]);
      check("R9 irq", 32'(irq), 32'(ei));
      check("R10 rsp_valid", 32'(rsp_valid), 32'(exp_rv));
      check("R10 bus_ready", 32'(bus_ready), 32'd1);
      if (exp_rv) check({exp_tag, " rsp_data"}, rsp_data, exp_rd);
    end
  end

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_valid = 1'b1; bus_write = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_valid = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_valid = 1'b1; bus_write = 1'b0; bus_addr = a;
    @(negedge clk);
    bus_valid = 1'b0;
    d = rsp_data;
  endtask

  task automatic rd_expect(input string tag, input logic [7:0] a, input logic [31:0] e);
    logic [31:0] d;
    rd(a, d);
    check(tag, d, e);
  endtask

  task automatic finish_run();
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1;
      total++;
      bad++;
      $display("FAIL watchdog actual=running expected=finished");
      finish_run();
    end
  end

  initial begin
    logic [31:0] d;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    check("R1 irq", 32'(irq), 32'd0);
    check("R1 rsp_valid", 32'(rsp_valid), 32'd0);
    rd_expect("R1 count", 8'h08, 32'd0);
    rd_expect("R1 full", 8'h12, 32'd0);
    rd_expect("R1 raw", 8'h20, 32'd0);
    rd_expect("R1 enable", 8'h2E, 32'd0);

    // R6 enable user 1 for queue 2 arrival (bit 4)
    wr(8'h26, 32'h10);
    rd_expect("R6 set", 8'h26, 32'h10);
    wr(8'h26, 32'h0);
    rd_expect("R6 zero write", 8'h27, 32'h10);

    // R2 fill queue 2
    for (int i = 0; i < 4; i++) wr(8'h02, 32'hA0 + 32'(i));
    rd_expect("R2 count", 8'h0A, 32'd4);
    rd_expect("R2 full", 8'h12, 32'd1);
    check("R9 irq user1", 32'(irq), 32'b0010);
    rd_expect("R7 raw user0", 8'h20, 32'h10);

    // R4 write to full queue dropped
    wr(8'h02, 32'hDEAD);
    rd_expect("R4 count", 8'h0A, 32'd4);
    for (int i = 0; i < 4; i++) rd_expect("R3 order", 8'h02, 32'hA0 + 32'(i));
    rd_expect("R7 space bit", 8'h20, 32'h30);
    rd_expect("R5 empty read", 8'h02, 32'hA3);
    rd_expect("R5 count", 8'h0A, 32'd0);

    // R8 / R9 status clear
    rd_expect("R9 masked", 8'h25, 32'h10);
    wr(8'h25, 32'h10);
    check("R8 irq cleared", 32'(irq), 32'd0);
    rd_expect("R8 raw user1", 8'h24, 32'h20);
    rd_expect("R8 other user kept", 8'h20, 32'h30);
    rd_expect("R8 no event", 8'h02, 32'hA3);
    check("R8 still low", 32'(irq), 32'd0);
    wr(8'h02, 32'h77);
    check("R8 new event", 32'(irq), 32'b0010);

    // R11 independence
    wr(8'h05, 32'h55);
    rd_expect("R11 q2 count", 8'h0A, 32'd1);
    rd_expect("R11 q5 count", 8'h0D, 32'd1);
    rd_expect("R11 q5 data", 8'h05, 32'h55);
    rd_expect("R11 q2 data", 8'h02, 32'h77);

    // R6 clear, R10 unmapped
    wr(8'h27, 32'h10);
    rd_expect("R6 clear", 8'h26, 32'h0);
    check("R6 irq off", 32'(irq), 32'd0);
    rd_expect("R10 unmapped", 8'hF0, 32'd0);

    // random traffic compared against the model every cycle
    for (int n = 0; n < 4000; n++) begin
      logic [7:0] a;
      int k;
      k = int'($urandom_range(0, 9));
      case (k)
        0, 1, 2, 3: a = 8'($urandom_range(0, 7));
        4:          a = 8'h08 + 8'($urandom_range(0, 7));
        5:          a = 8'h10 + 8'($urandom_range(0, 7));
        6, 7, 8:    a = 8'h20 + 8'($urandom_range(0, 15));
        default:    a = 8'hF0;
      endcase
      if ($urandom_range(0, 1) == 1) wr(a, $urandom);
      else rd(a, d);
    end

    done = 1;
    finish_run();
  end
endmodule